// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits between a synchronous requester and an asynchronous parallel mask ROM. The ROM can be organised as 16-bit words or as 8-bit bytes and has page-mode reads. The requester offers one read at a time with a valid/ready handshake, an address and a byte-mode flag. The controller drives the ROM address, chip-enable, output-enable and organisation-select pins. In byte mode it also drives the extra least-significant address bit, which shares the top data pin. It then holds everything steady for a counted number of clock cycles, captures the data bus and returns the result with a one-cycle response strobe.

The controller records which page was last read, and in which organisation. A read that falls in that page while the chip is still enabled uses the short page-hit wait. Any other read uses the full random-access wait. When the organisation changes, both enables are released for a turnaround gap first, so the ROM stops driving the shared top pin before the controller drives it. When no request arrives for a programmable number of cycles, chip enable is released, which puts the ROM in standby and forgets the open page.

Top module: `pmr_reader`

## Requirements
- R1: After reset, rom_ce_n and rom_oe_n are 1, req_ready is 1, rsp_valid is 0 and rom_amin1_oe is 0.
- R2: A read that is not a page hit and needs no organisation change raises rsp_valid exactly MISS_WAIT clock edges after the edge that accepted it.
- R3: A read that hits the open page raises rsp_valid exactly HIT_WAIT clock edges after acceptance. A hit needs the chip still enabled, the same organisation and the same page number.
- R4: In word mode (req_byte = 0), rom_addr carries req_addr[19:0], bit 20 of req_addr is ignored, rom_byte_n is 1 and rsp_data is the 16-bit ROM word at that address.
- R5: In byte mode (req_byte = 1), rom_addr carries req_addr[20:1], rom_amin1_o carries req_addr[0] with rom_amin1_oe = 1, rom_byte_n is 0, and rsp_data is {8'h00, byte}. The byte is the low half of the addressed word when req_addr[0] = 0 and the high half when it is 1.
- R6: While rom_oe_n stays low, rom_addr and rom_amin1_o do not change, so data is captured before the address moves.
- R7: req_ready falls on the edge after acceptance and stays low until the rsp_valid cycle. rsp_valid is a single-cycle pulse.
- R8: rom_oe_n is low only while rom_ce_n is low. Captured data comes only from a cycle in which the outputs were enabled.
- R9: After IDLE_TIMEOUT consecutive cycles with req_ready high and req_valid low, rom_ce_n is 1. The next read is then a page miss. One idle cycle fewer keeps the page open.
- R10: A read whose organisation differs from the previous one holds rom_ce_n and rom_oe_n at 1 and rom_amin1_oe at 0 for TURN_CYC cycles, then performs a miss. rsp_valid rises TURN_CYC + MISS_WAIT edges after acceptance. Organisation is word after reset.
- R11: The page number is word address bits [19:3]. In word mode, reads differing only in word address bits [2:0] hit. In byte mode, reads differing only in byte address bits [3:0] hit, including a change of the extra low bit alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 21 | Byte address in byte mode, word address in bits [19:0] in word mode |
| req_byte | input | 1 | 1 selects byte organisation, 0 word organisation |
| rsp_valid | output | 1 | One-cycle strobe marking rsp_data |
| rsp_data | output | 16 | Read result, upper byte zero in byte mode |
| rom_addr | output | 20 | ROM word address pins |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM organisation select, low for byte mode |
| rom_dq_i | input | 16 | ROM data bus as seen by the controller |
| rom_amin1_o | output | 1 | Extra low address bit driven onto the top data pin in byte mode |
| rom_amin1_oe | output | 1 | Drive enable for rom_amin1_o |

## Verification
The assertions treat a requester cycle with req_ready high and req_valid low as idle time toward standby. They also take for granted that a request is offered only through req_valid, with no side channel that reopens the chip. The bench raises req_valid for exactly the accepting cycle and drops it before the next edge. It chooses idle gaps around the timeout boundary, so both sides of the standby rule occur. Its ROM model returns correct data only when the address has been stable for the hit or miss wait since the last in-page or page change, or since chip enable fell, and returns a junk pattern otherwise. A wrong wait count therefore also shows up as wrong data.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int PMR_WORD_AW  = 20;
    localparam int PMR_REQ_AW   = PMR_WORD_AW + 1;
    localparam int PMR_DW       = 16;
    localparam int PMR_LANE_W   = 8;
    localparam int PMR_INPAGE_W = 3;
    localparam int PMR_PAGE_W   = PMR_WORD_AW - PMR_INPAGE_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TURN   = 2'd1,
        ST_ACCESS = 2'd2
    } pmr_state_e;

    typedef struct packed {
        logic [PMR_WORD_AW-1:0] word_addr;
        logic                   lsb;
    } pmr_loc_t;

    function automatic pmr_loc_t pmr_decode(input logic [PMR_REQ_AW-1:0] a,
                                            input logic byte_mode);
        pmr_loc_t l;
        if (byte_mode) begin
            l.word_addr = a[PMR_REQ_AW-1:1];
            l.lsb       = a[0];
        end else begin
            l.word_addr = a[PMR_WORD_AW-1:0];
            l.lsb       = 1'b0;
        end
        return l;
    endfunction

    function automatic logic [PMR_PAGE_W-1:0] pmr_page_of(input logic [PMR_WORD_AW-1:0] wa);
        return wa[PMR_WORD_AW-1:PMR_INPAGE_W];
    endfunction

endpackage

// File: rtl/pmr_wait_timer.sv
module pmr_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pmr_idle_timer.sv
module pmr_idle_timer #(
    parameter int LIMIT = 16,
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = count_en && (cnt_q == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !count_en || expire) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pmr_page_tracker.sv
module pmr_page_tracker
    import pmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  set,
    input  logic [PMR_PAGE_W-1:0] set_page,
    input  logic                  set_mode,
    input  logic [PMR_PAGE_W-1:0] q_page,
    input  logic                  q_mode,
    output logic                  hit
);
    logic                  open_q;
    logic [PMR_PAGE_W-1:0] page_q;
    logic                  mode_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            open_q <= 1'b0;
            page_q <= '0;
            mode_q <= 1'b0;
        end else if (set) begin
            open_q <= 1'b1;
            page_q <= set_page;
            mode_q <= set_mode;
        end
    end

    assign hit = open_q && (page_q == q_page) && (mode_q == q_mode);
endmodule

// File: rtl/pmr_lane_unpack.sv
module pmr_lane_unpack #(
    parameter int DW     = 16,
    parameter int LANE_W = 8
) (
    input  logic          byte_mode,
    input  logic [DW-1:0] dq,
    output logic [DW-1:0] data
);
    localparam int LANES = DW / LANE_W;

    assign data[LANE_W-1:0] = dq[LANE_W-1:0];

    for (genvar g = 1; g < LANES; g++) begin : g_upper
        assign data[g*LANE_W +: LANE_W] = byte_mode ? '0 : dq[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pmr_reader.sv
module pmr_reader
    import pmr_pkg::*;
#(
    parameter int MISS_WAIT    = 6,
    parameter int HIT_WAIT     = 3,
    parameter int TURN_CYC     = 2,
    parameter int IDLE_TIMEOUT = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [PMR_REQ_AW-1:0]  req_addr,
    input  logic                   req_byte,
    output logic                   rsp_valid,
    output logic [PMR_DW-1:0]      rsp_data,
    output logic [PMR_WORD_AW-1:0] rom_addr,
    output logic                   rom_ce_n,
    output logic                   rom_oe_n,
    output logic                   rom_byte_n,
    input  logic [PMR_DW-1:0]      rom_dq_i,
    output logic                   rom_amin1_o,
    output logic                   rom_amin1_oe
);
    localparam int TMR_MAX = (MISS_WAIT > TURN_CYC) ? MISS_WAIT : TURN_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int IDLE_W  = $clog2(IDLE_TIMEOUT + 1);

    pmr_state_e          state_q;
    pmr_loc_t            loc_q;
    pmr_loc_t            req_loc;
    logic                mode_q;
    logic                ce_n_q, oe_n_q, a1oe_q;
    logic                rsp_valid_q;
    logic [PMR_DW-1:0]   rsp_data_q;
    logic [PMR_DW-1:0]   lane_data;

    logic                accept, mode_switch, page_hit;
    logic                tmr_load, tmr_zero;
    logic [TMR_W-1:0]    tmr_val;
    logic                idle_en, idle_expire;
    logic                trk_clr, trk_set;

    assign req_loc     = pmr_decode(req_addr, req_byte);
    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign mode_switch = (req_byte != mode_q);

    // wait-state selection
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            tmr_load = 1'b1;
            if (mode_switch)   tmr_val = TMR_W'(TURN_CYC - 1);
            else if (page_hit) tmr_val = TMR_W'(HIT_WAIT - 1);
            else               tmr_val = TMR_W'(MISS_WAIT - 1);
        end else if ((state_q == ST_TURN) && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(MISS_WAIT - 1);
        end
    end

    pmr_wait_timer #(.CNT_W(TMR_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign idle_en = (state_q == ST_IDLE) && !req_valid && !ce_n_q;

    pmr_idle_timer #(.LIMIT(IDLE_TIMEOUT), .CNT_W(IDLE_W)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .count_en (idle_en),
        .expire   (idle_expire)
    );

    assign trk_clr = (accept && mode_switch) || idle_expire;
    assign trk_set = (state_q == ST_ACCESS) && tmr_zero;

    pmr_page_tracker u_trk (
        .clk      (clk),
        .rst      (rst),
        .clr      (trk_clr),
        .set      (trk_set),
        .set_page (pmr_page_of(loc_q.word_addr)),
        .set_mode (mode_q),
        .q_page   (pmr_page_of(req_loc.word_addr)),
        .q_mode   (req_byte),
        .hit      (page_hit)
    );

    pmr_lane_unpack #(.DW(PMR_DW), .LANE_W(PMR_LANE_W)) u_lane (
        .byte_mode (mode_q),
        .dq        (rom_dq_i),
        .data      (lane_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            loc_q       <= '0;
            mode_q      <= 1'b0;
            ce_n_q      <= 1'b1;
            oe_n_q      <= 1'b1;
            a1oe_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        loc_q  <= req_loc;
                        mode_q <= req_byte;
                        if (mode_switch) begin
                            state_q <= ST_TURN;
                            ce_n_q  <= 1'b1;
                            oe_n_q  <= 1'b1;
                            a1oe_q  <= 1'b0;
                        end else begin
                            state_q <= ST_ACCESS;
                            ce_n_q  <= 1'b0;
                            oe_n_q  <= 1'b0;
                            a1oe_q  <= req_byte;
                        end
                    end else if (idle_expire) begin
                        ce_n_q <= 1'b1;
                    end
                end
                ST_TURN: begin
                    if (tmr_zero) begin
                        state_q <= ST_ACCESS;
                        ce_n_q  <= 1'b0;
                        oe_n_q  <= 1'b0;
                        a1oe_q  <= mode_q;
                    end
                end
                ST_ACCESS: begin
                    if (tmr_zero) begin
                        state_q     <= ST_IDLE;
                        oe_n_q      <= 1'b1;
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= lane_data;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign rsp_valid    = rsp_valid_q;
    assign rsp_data     = rsp_data_q;
    assign rom_addr     = loc_q.word_addr;
    assign rom_amin1_o  = loc_q.lsb;
    assign rom_amin1_oe = a1oe_q;
    assign rom_ce_n     = ce_n_q;
    assign rom_oe_n     = oe_n_q;
    assign rom_byte_n   = !mode_q;
endmodule

// File: rtl/pmr_reader_chk.sv
module pmr_reader_chk
    import pmr_pkg::*;
#(
    parameter int IDLE_TIMEOUT = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   rsp_valid,
    input logic [PMR_WORD_AW-1:0] rom_addr,
    input logic                   rom_ce_n,
    input logic                   rom_oe_n,
    input logic                   rom_byte_n,
    input logic                   rom_amin1_o,
    input logic                   rom_amin1_oe
);
    localparam int CW = $clog2(IDLE_TIMEOUT + 1);
    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || !(req_ready && !req_valid)) idle_cnt <= '0;
        else if (idle_cnt != CW'(IDLE_TIMEOUT)) idle_cnt <= idle_cnt + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rom_ce_n && rom_oe_n && req_ready && !rsp_valid && !rom_amin1_oe));

    assert_a1_only_byte_R5: assert property (@(posedge clk) disable iff (rst)
        rom_amin1_oe |-> !rom_byte_n);

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!rom_oe_n && $past(!rom_oe_n)) |-> ($stable(rom_addr) && $stable(rom_amin1_o)));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_oe_within_ce_R8: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> !rom_ce_n);

    assert_capture_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!rom_oe_n));

    assert_idle_standby_R9: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt == CW'(IDLE_TIMEOUT)) |-> rom_ce_n);

endmodule

bind pmr_reader pmr_reader_chk #(.IDLE_TIMEOUT(IDLE_TIMEOUT)) u_chk (.*);

// File: tb/pmr_reader_tb.sv
module pmr_reader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MISS   = 6;
    localparam int HIT    = 3;
    localparam int TURN   = 2;
    localparam int IDLE_T = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [20:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [19:0] rom_addr;
    logic        rom_ce_n, rom_oe_n, rom_byte_n;
    logic [15:0] rom_dq;
    logic        rom_amin1_o, rom_amin1_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmr_reader #(.MISS_WAIT(MISS), .HIT_WAIT(HIT), .TURN_CYC(TURN), .IDLE_TIMEOUT(IDLE_T)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n),
        .rom_dq_i(rom_dq), .rom_amin1_o(rom_amin1_o), .rom_amin1_oe(rom_amin1_oe)
    );

    function automatic logic [15:0] rom_word(input logic [19:0] a);
        logic [15:0] m;
        m = a[15:0] * 16'h9E37;
        return m ^ {a[19:16], a[19:8]} ^ 16'h1F2E;
    endfunction

    // ROM model: valid data only after the access time has elapsed
    logic [17:0] prev_page = '0;
    logic [20:0] prev_loc  = '0;
    logic        prev_ce_n = 1'b1;
    int          full_cnt  = 0;
    int          page_cnt  = 0;

    always @(negedge clk) begin
        logic [17:0] kp;
        logic [20:0] kl;
        logic        brk;
        kp  = {rom_byte_n, rom_addr[19:3]};
        kl  = {rom_addr, rom_amin1_o};
        brk = (prev_ce_n && !rom_ce_n) || (kp != prev_page);
        if (brk) full_cnt = 1; else if (full_cnt < 255) full_cnt++;
        if (brk || kl != prev_loc) page_cnt = 1; else if (page_cnt < 255) page_cnt++;
        prev_page = kp;
        prev_loc  = kl;
        prev_ce_n = rom_ce_n;
    end

    always_comb begin
        logic [15:0] w;
        w = rom_word(rom_addr);
        if (!rom_ce_n && !rom_oe_n && full_cnt >= MISS && page_cnt >= HIT) begin
            if (rom_byte_n) rom_dq = w;
            else if (rom_amin1_oe) rom_dq = {8'hE7, rom_amin1_o ? w[15:8] : w[7:0]};
            else rom_dq = 16'hE73C;
        end else begin
            rom_dq = 16'h5AA5;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bench view of the controller state
    logic        b_open = 1'b0;
    logic [16:0] b_page = '0;
    logic        b_mode = 1'b0;
    int          b_idle = 0;

    task automatic wait_idle(input int n);
        repeat (n) @(negedge clk);
        b_idle += n;
    endtask

    task automatic do_read(input logic [20:0] addr, input logic bm, input int gap);
        logic [19:0] wa;
        logic [16:0] pg;
        logic [15:0] w, exp_d;
        int exp_lat;
        int n;
        bit turn;
        wait_idle(gap);
        if (b_idle >= IDLE_T) b_open = 1'b0;
        wa = bm ? addr[20:1] : addr[19:0];
        pg = wa[19:3];
        turn = (bm != b_mode);
        if (turn) begin exp_lat = TURN + MISS; b_open = 1'b0; end
        else if (b_open && pg == b_page) exp_lat = HIT;   // R3 / R11
        else exp_lat = MISS;                              // R2
        w = rom_word(wa);
        exp_d = bm ? {8'h00, (addr[0] ? w[15:8] : w[7:0])} : w;

        check("R7 ready before accept", req_ready, 1);
        req_addr  = addr;
        req_byte  = bm;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 ready low after accept", req_ready, 0);
        if (turn) begin
            check("R10 enables released in turnaround", {rom_ce_n, rom_oe_n, rom_amin1_oe}, 3'b110);
        end else begin
            check("R4 R5 address pins", rom_addr, wa);
            check("R4 R5 organisation pin", rom_byte_n, !bm);
            check("R8 enables active", {rom_ce_n, rom_oe_n}, 2'b00);
            if (bm) check("R5 extra low bit", {rom_amin1_oe, rom_amin1_o}, {1'b1, addr[0]});
        end
        n = 0;
        while (!rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
            if (!rsp_valid && req_ready) check("R7 ready held low while busy", req_ready, 0);
        end
        if (turn)         check("R10 latency with turnaround", n, exp_lat);
        else if (exp_lat == HIT) check("R3 page-hit latency", n, exp_lat);
        else              check("R2 page-miss latency", n, exp_lat);
        if (bm) check("R5 byte data", rsp_data, exp_d);
        else    check("R4 word data", rsp_data, exp_d);
        b_open = 1'b1;
        b_page = pg;
        b_mode = bm;
        b_idle = 0;
    endtask

    function automatic logic [20:0] in_page(input logic [16:0] pg, input logic bm, input logic [31:0] r);
        if (bm) return {pg, r[3:0]};
        else    return {r[4], pg, r[2:0]};
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 chip enable high", rom_ce_n, 1);
        check("R1 output enable high", rom_oe_n, 1);
        check("R1 ready", req_ready, 1);
        check("R1 no response", rsp_valid, 0);
        check("R1 low-bit driver off", rom_amin1_oe, 0);

        // R2 first read after reset is a miss; R4 bit 20 ignored
        do_read(21'h1ABCD5, 1'b0, 0);
        @(negedge clk); b_idle++;
        check("R7 response is one cycle", rsp_valid, 0);
        // R11 word in-page hits, neighbouring page misses
        do_read(21'h0ABCD0, 1'b0, 0);
        do_read(21'h0ABCD7, 1'b0, 1);
        do_read(21'h0ABCD8, 1'b0, 0);

        // R9 timeout boundary: one short keeps the page, full timeout closes it
        do_read(21'h0ABCD9, 1'b0, IDLE_T - 1);
        wait_idle(IDLE_T - 1);
        check("R9 chip still enabled one cycle before timeout", rom_ce_n, 0);
        wait_idle(1);
        check("R9 standby after timeout", rom_ce_n, 1);
        do_read(21'h0ABCDA, 1'b0, 0);

        // R10 switch to byte mode, R5/R11 A-1 only change is a hit
        do_read(21'h13578A, 1'b1, 0);
        do_read(21'h13578B, 1'b1, 0);
        do_read(21'h135780, 1'b1, 2);
        do_read(21'h13579F, 1'b1, 0);
        // R10 back to word mode
        do_read(21'h09ABC3, 1'b0, 0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic bm;
            logic [20:0] a;
            int gap;
            r  = $urandom;
            bm = (r[7:0] < 8'd20) ? !b_mode : b_mode;
            if (r[15:8] < 8'd150) a = in_page(b_page, bm, $urandom);
            else                  a = 21'($urandom);
            r = $urandom;
            if (r[3:0] == 4'd0)      gap = IDLE_T - 1 + int'(r[4]);
            else                     gap = int'(r[6:5]);
            do_read(a, bm, gap);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule